// File: doc/BRIEF.md
# Narrow External Bus Sequencer

This block sits between a core's memory port and a 16-bit external data bus. The core issues one request at a time: a byte, a halfword, a 32-bit word, or a 128-bit line. The block turns each request into one or more halfword bus cycles.

For each cycle it drives:
- a halfword address,
- a bus-start strobe,
- a burst flag,
- a read/write line,
- two byte-lane enables,
- a fetch/operand status line,
- a user/I-O space line.

Every beat waits for the addressed slave to pull data-complete low. Read halfwords are packed into the returned word or line. Write data is split onto the correct lanes.

A word is always moved as two beats, with the more significant half first. A line is moved as eight beats. The line burst starts at the requested halfword and wraps inside the 16-byte block, so the critical halfword arrives first. When the last beat has completed, the block pulses an acknowledge with the assembled read data. After that it returns to idle and can take the next request.

Top module: `extbus_seq`

## Requirements
- R1: During and after reset, with no request pending, `bus_start_n` and `bus_burst_n` are high, `rsp_ack` is low and `req_ready` is high.
- R2: A word request (`req_size`=2) runs two beats. Address bit 1 of the request is treated as 0. The first beat has `bus_addr` bit 0 low, and its data lands in `rsp_rdata[31:16]`. The second beat has `bus_addr` bit 0 high, and its data lands in `rsp_rdata[15:0]`. All other `rsp_rdata` bits are 0.
- R3: A line request (`req_size`=3) runs 8 beats and is always a read, whatever `req_write` says. Beat k uses halfword index (start+k) mod 8 inside the 16-byte block, where start is `req_addr[3:1]`. Data for halfword index j lands in `rsp_rdata[127-16j -: 16]`.
- R4: `bus_burst_n` is low on every beat of a word or line transfer. It is high on byte and halfword transfers.
- R5: `bus_start_n` is low for exactly one cycle, the first cycle of each beat.
- R6: A beat ends in the cycle where `bus_done_n` is sampled low, which may be the strobe cycle itself. With W wait cycles per beat and N beats, `rsp_ack` appears N·(W+1) cycles after the accepting edge.
- R7: On reads (`bus_rd_wr_n`=1) both `bus_ben_hi_n` and `bus_ben_lo_n` are low.
- R8: On a word write, the first beat carries `req_wdata[31:16]` and the second beat carries `req_wdata[15:0]`, with both enables low. A halfword write carries `req_wdata[15:0]` with both enables low. A byte write with `req_addr[0]`=0 lowers only `bus_ben_hi_n` and puts `req_wdata[7:0]` on `bus_dout[15:8]`. A byte write with `req_addr[0]`=1 lowers only `bus_ben_lo_n` and puts the byte on `bus_dout[7:0]`.
- R9: `bus_status` is 0 for a fetch (`req_fetch`=1) and 1 for an operand access. `bus_space` equals `req_io`. Both hold steady for the whole transaction.
- R10: A request is taken only when `req_ready` is high, which means idle. `rsp_ack` is a one-cycle pulse. A request raised while busy is ignored: it causes no extra beats, and it does not change the addresses of the running transfer.
- R11: For byte and halfword requests, `bus_addr` equals `req_addr[23:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | High when idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 line |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = operand |
| req_io | input | 1 | 1 = I/O space, 0 = user space |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 128 | Assembled read data |
| bus_addr | output | 23 | Halfword address (byte address bits 23..1) |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_start_n | output | 1 | Start strobe, low in the first cycle of each beat |
| bus_burst_n | output | 1 | Low through multi-beat transfers |
| bus_rd_wr_n | output | 1 | 1 = read, 0 = write |
| bus_ben_hi_n | output | 1 | Enable for data bits 15..8 |
| bus_ben_lo_n | output | 1 | Enable for data bits 7..0 |
| bus_status | output | 1 | 0 = fetch, 1 = operand |
| bus_space | output | 1 | 0 = user, 1 = I/O |
| bus_done_n | input | 1 | Slave data-complete, active low |

## Verification
The embedded properties check, on every cycle:
- the strobe lasts exactly one cycle unless data-complete arrives with it;
- a burst always opens with a strobe;
- both lanes are enabled on every read strobe;
- the address holds steady while a beat waits;
- the halfword index steps by one, modulo the line, between beats;
- status and space stay constant during a transaction;
- the acknowledge is a single-cycle pulse.

Only the bench scenarios can show that the right data lands in the right slot, that the wrap order is correct for every start offset, and that the completion latency is right for each wait count. The same applies to the write lane selection for each size, and to a request raised while busy leaving the bus untouched.

// File: rtl/ebs_pkg.sv
// Shared types for the narrow external bus sequencer.
package ebs_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } xfer_size_e;
endpackage

// File: rtl/ebs_addr_gen.sv
// Beat address generator.
// Produces the halfword bus address for the current beat. The low OFF_W
// bits of the latched base address are advanced by the beat count and wrap
// inside the line, while the upper bits stay fixed.
// Assumes: the base of a word transfer has bit 0 cleared, so one beat step
// never carries out of the word.
module ebs_addr_gen #(
    parameter int HA_W  = 23,
    parameter int OFF_W = 3
) (
    input  logic [HA_W-1:0]  base,
    input  logic [OFF_W-1:0] cnt,
    output logic [HA_W-1:0]  addr
);
    // Wrap the in-line offset and keep the block bits.
    always_comb begin
        addr = {base[HA_W-1:OFF_W], base[OFF_W-1:0] + cnt};
    end
endmodule

// File: rtl/ebs_lane_ctl.sv
// Byte-lane and direction control.
// Decides the read/write line, the two lane enables and the outgoing data for
// the current beat. Bus data bits 15..8 form the upper lane.
// Assumes: the write flag is already cleared for line transfers.
module ebs_lane_ctl
    import ebs_pkg::*;
(
    input  logic        busy,
    input  logic        write,
    input  xfer_size_e  size,
    input  logic        byte_sel,
    input  logic        second,
    input  logic [31:0] wdata,
    output logic        rd_wr_n,
    output logic        ben_hi_n,
    output logic        ben_lo_n,
    output logic [15:0] dout
);
    // Select enables and place write data by size and beat.
    always_comb begin
        rd_wr_n  = 1'b1;
        ben_hi_n = 1'b1;
        ben_lo_n = 1'b1;
        dout     = '0;
        if (busy) begin
            rd_wr_n = !write;
            if (!write) begin
                ben_hi_n = 1'b0;
                ben_lo_n = 1'b0;
            end else begin
                unique case (size)
                    SZ_BYTE: begin
                        if (byte_sel) begin
                            ben_lo_n = 1'b0;
                            dout     = {8'h00, wdata[7:0]};
                        end else begin
                            ben_hi_n = 1'b0;
                            dout     = {wdata[7:0], 8'h00};
                        end
                    end
                    SZ_HALF: begin
                        ben_hi_n = 1'b0;
                        ben_lo_n = 1'b0;
                        dout     = wdata[15:0];
                    end
                    default: begin
                        ben_hi_n = 1'b0;
                        ben_lo_n = 1'b0;
                        dout     = second ? wdata[15:0] : wdata[31:16];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ebs_rd_pack.sv
// Read data assembler.
// Places each completed read halfword into the response register:
// - line beats go to the slot of their halfword index, index 0 at the top;
// - word beats fill the upper half first, then the lower half;
// - single beats go to the lowest 16 bits.
// Assumes: clear is raised when a transaction is accepted.
module ebs_rd_pack
    import ebs_pkg::*;
#(
    parameter int LINE_BEATS = 8,
    parameter int OFF_W      = 3,
    parameter int LINE_W     = 16 * LINE_BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  xfer_size_e        size,
    input  logic              second,
    input  logic [OFF_W-1:0]  slot,
    input  logic [15:0]       din,
    output logic [LINE_W-1:0] rdata
);
    // Clear on accept, then write one halfword per completed read beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rdata <= '0;
        end else if (capture) begin
            unique case (size)
                SZ_LINE: rdata[(LINE_BEATS-1-int'(slot))*16 +: 16] <= din;
                SZ_WORD: begin
                    if (second) rdata[15:0]  <= din;
                    else        rdata[31:16] <= din;
                end
                default: rdata[15:0] <= din;
            endcase
        end
    end
endmodule

// File: rtl/extbus_seq.sv
// Narrow external bus sequencer (top).
// Accepts one core request at a time when idle and runs it as halfword beats
// on a 16-bit bus. Each beat opens with a one-cycle start strobe and ends in
// the cycle where data-complete is sampled low. Word and line transfers keep
// the burst flag low. After the last beat it pulses rsp_ack with the
// assembled read data.
// Assumes: LINE_BEATS is a power of two and at least 2; line requests are
// always reads.
module extbus_seq
    import ebs_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LINE_BEATS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic                       req_fetch,
    input  logic                       req_io,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [31:0]                req_wdata,
    output logic                       rsp_ack,
    output logic [16*LINE_BEATS-1:0]   rsp_rdata,
    output logic [ADDR_W-2:0]          bus_addr,
    output logic [15:0]                bus_dout,
    input  logic [15:0]                bus_din,
    output logic                       bus_start_n,
    output logic                       bus_burst_n,
    output logic                       bus_rd_wr_n,
    output logic                       bus_ben_hi_n,
    output logic                       bus_ben_lo_n,
    output logic                       bus_status,
    output logic                       bus_space,
    input  logic                       bus_done_n
);
    localparam int OFF_W  = $clog2(LINE_BEATS);
    localparam int LINE_W = 16 * LINE_BEATS;
    localparam int HA_W   = ADDR_W - 1;
    localparam logic [OFF_W-1:0] LAST_LINE = OFF_W'(LINE_BEATS - 1);
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(1);

    logic              busy_q, first_q, ack_q;
    logic              write_q, fetch_q, io_q, bsel_q;
    xfer_size_e        size_q, req_sz;
    logic [OFF_W-1:0]  cnt_q, last_q;
    logic [HA_W-1:0]   base_q;
    logic [31:0]       wdata_q;
    logic              accept, beat_done, last_beat, multi;

    // Decode the core request and the per-cycle beat events.
    always_comb begin
        req_sz    = xfer_size_e'(req_size);
        accept    = req_valid && !busy_q;
        beat_done = busy_q && !bus_done_n;
        last_beat = (cnt_q == last_q);
        multi     = (size_q == SZ_WORD) || (size_q == SZ_LINE);
    end

    // Latch the transaction attributes on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            fetch_q <= 1'b0;
            io_q    <= 1'b0;
            bsel_q  <= 1'b0;
            base_q  <= '0;
            last_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            size_q  <= req_sz;
            write_q <= req_write && (req_sz != SZ_LINE);
            fetch_q <= req_fetch;
            io_q    <= req_io;
            bsel_q  <= req_addr[0];
            base_q  <= (req_sz == SZ_WORD) ? {req_addr[ADDR_W-1:2], 1'b0}
                                           : req_addr[ADDR_W-1:1];
            last_q  <= (req_sz == SZ_LINE) ? LAST_LINE :
                       (req_sz == SZ_WORD) ? LAST_WORD : '0;
            wdata_q <= req_wdata;
        end
    end

    // Beat sequencer: strobe phase, beat count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                first_q <= 1'b1;
                cnt_q   <= '0;
            end else if (beat_done) begin
                if (last_beat) begin
                    busy_q  <= 1'b0;
                    first_q <= 1'b0;
                    ack_q   <= 1'b1;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                    first_q <= 1'b1;
                end
            end else begin
                first_q <= 1'b0;
            end
        end
    end

    ebs_addr_gen #(.HA_W(HA_W), .OFF_W(OFF_W)) u_addr (
        .base (base_q),
        .cnt  (cnt_q),
        .addr (bus_addr)
    );

    ebs_lane_ctl u_lane (
        .busy     (busy_q),
        .write    (write_q),
        .size     (size_q),
        .byte_sel (bsel_q),
        .second   (cnt_q[0]),
        .wdata    (wdata_q),
        .rd_wr_n  (bus_rd_wr_n),
        .ben_hi_n (bus_ben_hi_n),
        .ben_lo_n (bus_ben_lo_n),
        .dout     (bus_dout)
    );

    ebs_rd_pack #(.LINE_BEATS(LINE_BEATS), .OFF_W(OFF_W), .LINE_W(LINE_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (beat_done && !write_q),
        .size    (size_q),
        .second  (cnt_q[0]),
        .slot    (bus_addr[OFF_W-1:0]),
        .din     (bus_din),
        .rdata   (rsp_rdata)
    );

    // Drive the handshake and the bus control lines from the state.
    always_comb begin
        req_ready   = !busy_q;
        rsp_ack     = ack_q;
        bus_start_n = !(busy_q && first_q);
        bus_burst_n = !(busy_q && multi);
        bus_status  = !fetch_q;
        bus_space   = io_q;
    end

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_start_n && bus_done_n) |=> bus_start_n);

    // R4
    burst_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_burst_n) |-> !bus_start_n);

    // R7
    read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_start_n && bus_rd_wr_n) |-> (!bus_ben_hi_n && !bus_ben_lo_n));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && bus_done_n) |=> $stable(bus_addr));

    // R3
    wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !last_beat) |=>
            (bus_addr[OFF_W-1:0] == $past(bus_addr[OFF_W-1:0]) + 1'b1));

    // R9
    attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(bus_status) && $stable(bus_space)));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |=> !rsp_ack);
endmodule

// File: tb/sim_extbus_seq.sv
// Bench for extbus_seq: sweeps sizes, start offsets, wait counts and
// attributes against a behavioural slave, and computes expected values
// arithmetically.
module sim_extbus_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_io = 1'b0;
    logic [1:0]   req_size = 2'd0;
    logic [23:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, rsp_ack;
    logic [127:0] rsp_rdata;
    logic [22:0]  bus_addr;
    logic [15:0]  bus_dout;
    logic [15:0]  bus_din = '0;
    logic         bus_start_n, bus_burst_n, bus_rd_wr_n, bus_ben_hi_n, bus_ben_lo_n;
    logic         bus_status, bus_space;
    logic         bus_done_n = 1'b1;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    extbus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_fetch(req_fetch),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_start_n(bus_start_n),
        .bus_burst_n(bus_burst_n), .bus_rd_wr_n(bus_rd_wr_n),
        .bus_ben_hi_n(bus_ben_hi_n), .bus_ben_lo_n(bus_ben_lo_n),
        .bus_status(bus_status), .bus_space(bus_space), .bus_done_n(bus_done_n)
    );

    function automatic logic [15:0] hv(logic [22:0] x);
        logic [15:0] p;
        p = x[15:0] * 16'd40503;
        return p + {9'd0, x[22:16]} + 16'h1357;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural slave with per-beat logging
    int          sl_wait = 0;
    bit          sl_act = 0;
    int          sl_cnt = 0;
    int          sl_bs = 0;
    int          nbeat = 0;
    logic [22:0] lg_addr [16];
    logic        lg_hi [16], lg_lo [16], lg_rw [16], lg_burst [16], lg_st [16], lg_sid [16];
    logic [15:0] lg_dout [16];
    int          lg_bs [16];

    always @(negedge clk) begin
        if (!bus_done_n) begin
            bus_done_n = 1'b1;
            sl_act = 0;
        end
        if (!bus_start_n) begin
            if (!sl_act) begin
                sl_act = 1; sl_cnt = 0; sl_bs = 1;
            end else begin
                sl_bs++; sl_cnt++;
            end
        end else if (sl_act) begin
            sl_cnt++;
        end
        if (sl_act && sl_cnt == sl_wait) begin
            bus_done_n = 1'b0;
            bus_din = hv(bus_addr);
            if (nbeat < 16) begin
                lg_addr[nbeat] = bus_addr;   lg_hi[nbeat] = bus_ben_hi_n;
                lg_lo[nbeat] = bus_ben_lo_n; lg_rw[nbeat] = bus_rd_wr_n;
                lg_burst[nbeat] = bus_burst_n; lg_st[nbeat] = bus_status;
                lg_sid[nbeat] = bus_space;   lg_dout[nbeat] = bus_dout;
                lg_bs[nbeat] = sl_bs;
            end
            nbeat++;
        end
    end

    task automatic txn(input bit wr, input logic [1:0] sz, input logic [23:0] a,
                       input bit fe, input bit io, input logic [31:0] wd,
                       input int w, input bit poke);
        int n;
        int lat;
        logic [22:0] ha;
        logic [22:0] ea;
        logic [127:0] exp;
        bit is_wr;
        sl_wait = w;
        nbeat = 0;
        n = (sz == 2'd3) ? 8 : (sz == 2'd2) ? 2 : 1;
        is_wr = wr && (sz != 2'd3);
        ha = a[23:1];
        if (sz == 2'd2) ha[0] = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_fetch = fe; req_io = io; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        req_addr = a ^ 24'h000040;
        req_size = 2'd3;
        req_valid = poke;
        while (!rsp_ack && lat < 400) begin
            @(negedge clk);
            lat++;
            if (lat == 3) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        chk(lat == n * (w + 1) + 1, "R6 completion latency", 128'(lat), 128'(n * (w + 1) + 1));
        chk(nbeat == n, "R10 beat count", 128'(nbeat), 128'(n));
        exp = '0;
        for (int k = 0; k < n && k < 16; k++) begin
            if (sz == 2'd3)      ea = {ha[22:3], ha[2:0] + 3'(k)};
            else if (sz == 2'd2) ea = {ha[22:1], 1'(k)};
            else                 ea = ha;
            chk(lg_addr[k] == ea, (sz == 2'd3) ? "R3 wrap address" :
                (sz == 2'd2) ? "R2 word address" : "R11 single address",
                128'(lg_addr[k]), 128'(ea));
            chk(lg_bs[k] == 1, "R5 one strobe per beat", 128'(lg_bs[k]), 128'd1);
            chk(lg_burst[k] == !(sz >= 2'd2), "R4 burst flag", 128'(lg_burst[k]),
                128'(!(sz >= 2'd2)));
            chk(lg_rw[k] == !is_wr, "R3 direction", 128'(lg_rw[k]), 128'(!is_wr));
            chk(lg_st[k] == !fe && lg_sid[k] == io, "R9 status and space",
                128'({lg_st[k], lg_sid[k]}), 128'({!fe, io}));
            if (!is_wr) begin
                chk(!lg_hi[k] && !lg_lo[k], "R7 read enables",
                    128'({lg_hi[k], lg_lo[k]}), 128'd0);
                if (sz == 2'd3)      exp[(7 - int'(ea[2:0])) * 16 +: 16] = hv(ea);
                else if (sz == 2'd2) exp[(1 - k) * 16 +: 16] = hv(ea);
                else                 exp[15:0] = hv(ea);
            end else if (sz == 2'd0) begin
                chk(lg_hi[k] == a[0] && lg_lo[k] == !a[0], "R8 byte lane",
                    128'({lg_hi[k], lg_lo[k]}), 128'({a[0], !a[0]}));
                chk((a[0] ? lg_dout[k][7:0] : lg_dout[k][15:8]) == wd[7:0],
                    "R8 byte data", 128'(lg_dout[k]), 128'(wd[7:0]));
            end else begin
                chk(!lg_hi[k] && !lg_lo[k], "R8 write enables",
                    128'({lg_hi[k], lg_lo[k]}), 128'd0);
                chk(lg_dout[k] == ((sz == 2'd2 && k == 0) ? wd[31:16] : wd[15:0]),
                    "R8 write data", 128'(lg_dout[k]),
                    128'((sz == 2'd2 && k == 0) ? wd[31:16] : wd[15:0]));
            end
        end
        if (!is_wr) begin
            chk(rsp_rdata == exp, (sz == 2'd3) ? "R3 line data" : "R2 read data",
                rsp_rdata, exp);
        end
        @(negedge clk);
        chk(rsp_ack == 1'b0, "R10 ack single pulse", 128'(rsp_ack), 128'd0);
        for (int i = 0; i < 3; i++) begin
            chk(bus_start_n && bus_burst_n, "R10 no stray cycle",
                128'({bus_start_n, bus_burst_n}), 128'd3);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_start_n && bus_burst_n && !rsp_ack && req_ready, "R1 reset state",
            128'({bus_start_n, bus_burst_n, rsp_ack, req_ready}), 128'b1101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_start_n && bus_burst_n && !rsp_ack && req_ready, "R1 idle state",
            128'({bus_start_n, bus_burst_n, rsp_ack, req_ready}), 128'b1101);
        // R3 line reads: every start offset, several wait counts
        for (int off = 0; off < 8; off++)
            for (int w = 0; w < 3; w++)
                txn(1'b0, 2'd3, 24'h5C3A40 + 24'(off * 2), off[0], w == 1,
                    32'h0, w, off == 3);
        // R3 line request with write flag still reads
        txn(1'b1, 2'd3, 24'h00012A, 1'b1, 1'b0, 32'hDEADBEEF, 1, 1'b0);
        // R2 word reads, including address bit 1 set
        for (int w = 0; w < 4; w++) begin
            txn(1'b0, 2'd2, 24'h000010, 1'b0, 1'b0, 32'h0, w, w >= 1);
            txn(1'b0, 2'd2, 24'h7FFFFC, 1'b1, 1'b1, 32'h0, w, 1'b0);
            txn(1'b0, 2'd2, 24'h123456, 1'b0, 1'b1, 32'h0, w, 1'b0);
        end
        // R8 writes of each size
        for (int w = 0; w < 2; w++) begin
            txn(1'b1, 2'd2, 24'hA0B0C4, 1'b0, 1'b0, 32'hCAFE1234, w, 1'b0);
            txn(1'b1, 2'd1, 24'h00F00E, 1'b0, 1'b1, 32'h0000ABCD, w, 1'b0);
            txn(1'b1, 2'd0, 24'h001000, 1'b0, 1'b0, 32'h000000A5, w, 1'b0);
            txn(1'b1, 2'd0, 24'h001001, 1'b1, 1'b1, 32'h0000005A, w, 1'b0);
        end
        // R11 single reads
        txn(1'b0, 2'd1, 24'hFFFFFE, 1'b0, 1'b1, 32'h0, 2, 1'b0);
        txn(1'b0, 2'd0, 24'h3456A7, 1'b1, 1'b0, 32'h0, 0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule